// File: doc/BRIEF.md
# Tamper Alarm Aggregator with Power-Up Arming

This block merges every tamper source of a security supervisor into one active-low alarm line. Four physical sense inputs are filtered against glitches and tested against their own idle level. Two of them idle high and two idle low. Four synchronous flags from the analog side are added to them: supply too high, supply too low, temperature too high and temperature too low. The alarm follows the conditions. It goes active while any condition is present and returns to idle as soon as none remains.

Detection is gated by a one-time arming step. The alarm stays quiet until the main supply has reported itself above the reset threshold for a full recovery period. After that the block stays armed until a power-on reset, even when it runs on battery power. A variant parameter chooses what an auxiliary output switch does while the alarm is active: it stays on, floats, or is pulled to ground.

Top module: `tamper_alarm_top`

## Requirements
- R1: Sense inputs `tp_in[0]` and `tp_in[2]` idle high and report tamper when low. Sense inputs `tp_in[1]` and `tp_in[3]` idle low and report tamper when high.
- R2: When the block is armed, a tamper level on any single sense input is enough to drive `alarm_n` low.
- R3: `alarm_n` is active-low. It is 1 during and after reset, and whenever no condition is present. At reset `aux_en` is 1 and `aux_gnd` is 0.
- R4: The alarm does not latch. One cycle after the last present condition clears, `alarm_n` returns to 1. While any condition is still present, the alarm stays active.
- R5: When the block is armed, `ovr_volt` or `und_volt` drives `alarm_n` low on the next clock edge.
- R6: When the block is armed, `ovr_temp` or `und_temp` drives `alarm_n` low on the next clock edge.
- R7: Each sense input has a two-flop synchronizer followed by a stability filter. A level that lasts fewer than FILT_CYCLES clock cycles has no effect. A level held for FILT_CYCLES+1 cycles is accepted, and the alarm responds within FILT_CYCLES+4 cycles of the input change.
- R8: The block arms only after `main_ok` has been 1 for RECOV_CYCLES consecutive cycles. Any cycle with `main_ok` at 0 restarts the count. Until the block is armed, `alarm_n` stays 1 whatever the conditions are.
- R9: Once armed, the block stays armed whatever `main_ok` does. Only `rst_n` low disarms it.
- R10: While the alarm is active, the auxiliary controls `{aux_en,aux_gnd}` take a value set by AUX_MODE: mode 0 gives 1,0 (stays on); mode 1 gives 0,0 (high impedance); mode 2 gives 0,1 (grounded). While the alarm is idle they are 1,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; also clears arming |
| main_ok | input | 1 | Main supply is above the reset threshold |
| tp_in | input | 4 | Raw physical tamper sense inputs |
| ovr_volt | input | 1 | Internal supply over-voltage flag |
| und_volt | input | 1 | Internal supply under-voltage flag |
| ovr_temp | input | 1 | Over-temperature flag |
| und_temp | input | 1 | Under-temperature flag |
| alarm_n | output | 1 | Security alarm, active low |
| aux_en | output | 1 | Auxiliary output switch enable |
| aux_gnd | output | 1 | Auxiliary output pull-to-ground enable |

## Verification
Each sense input is moved on its own to its tamper level and then back to idle. This shows that the per-input polarity is right and that each input can raise the alarm alone. A pulse one cycle shorter than the filter window is compared with a sustained level, which separates filtering from pass-through. The supply and temperature flags are raised before arming, with `main_ok` interrupted partway through the count, and then again after arming while on battery. Together these tell the arming gate apart from plain level gating. Overlapping conditions that are removed one at a time show that the alarm follows the conditions and does not latch. Three variant instances share the same stimulus to compare their auxiliary outputs.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

  typedef enum logic [1:0] {
    AUX_STAY_ON = 2'd0,
    AUX_FLOAT   = 2'd1,
    AUX_GROUND  = 2'd2
  } aux_mode_e;

  localparam int unsigned NUM_SENSE = 4;

  // Idle level of each sense input, bit i for tp_in[i].
  localparam logic [NUM_SENSE-1:0] SENSE_IDLE = 4'b0101;

  function automatic logic level_is_tamper(logic lvl, logic idle);
    return lvl != idle;
  endfunction

  // Returns {aux_en, aux_gnd} for a mode and alarm state.
  function automatic logic [1:0] aux_drive(aux_mode_e mode, logic active);
    logic [1:0] r;
    r = 2'b10;
    if (active) begin
      case (mode)
        AUX_STAY_ON: r = 2'b10;
        AUX_FLOAT:   r = 2'b00;
        AUX_GROUND:  r = 2'b01;
        default:     r = 2'b00;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/tamper_input_filter.sv
module tamper_input_filter #(
  parameter int unsigned FILT_CYCLES = 16,
  parameter logic        IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic hit
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic          sync_a, sync_b, level_q;
  logic [CW-1:0] stable_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a     <= IDLE_LVL;
      sync_b     <= IDLE_LVL;
      level_q    <= IDLE_LVL;
      stable_cnt <= '0;
    end else begin
      sync_a <= pin;
      sync_b <= sync_a;
      if (sync_b == level_q) begin
        stable_cnt <= '0;
      end else if (stable_cnt == LAST) begin
        level_q    <= sync_b;
        stable_cnt <= '0;
      end else begin
        stable_cnt <= stable_cnt + 1'b1;
      end
    end
  end

  assign hit = tamper_pkg::level_is_tamper(level_q, IDLE_LVL);

endmodule

// File: rtl/tamper_arm_gate.sv
module tamper_arm_gate #(
  parameter int unsigned RECOV_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok,
  output logic armed
);
  localparam int unsigned RW = $clog2(RECOV_CYCLES + 1);
  localparam logic [RW-1:0] LAST = RW'(RECOV_CYCLES - 1);

  logic [RW-1:0] recov_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      recov_cnt <= '0;
    end else if (!armed) begin
      if (!main_ok) begin
        recov_cnt <= '0;
      end else if (recov_cnt == LAST) begin
        armed     <= 1'b1;
        recov_cnt <= '0;
      end else begin
        recov_cnt <= recov_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tamper_alarm_top.sv
module tamper_alarm_top #(
  parameter int unsigned FILT_CYCLES  = 16,
  parameter int unsigned RECOV_CYCLES = 1024,
  parameter int unsigned AUX_MODE     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_ok,
  input  logic [3:0] tp_in,
  input  logic       ovr_volt,
  input  logic       und_volt,
  input  logic       ovr_temp,
  input  logic       und_temp,
  output logic       alarm_n,
  output logic       aux_en,
  output logic       aux_gnd
);
  import tamper_pkg::*;

  localparam aux_mode_e MODE = aux_mode_e'(AUX_MODE[1:0]);

  logic [NUM_SENSE-1:0] sense_hit;
  logic                 armed;
  logic                 phys_hit, volt_hit, temp_hit, any_cond, raise;

  for (genvar g = 0; g < NUM_SENSE; g++) begin : g_sense
    tamper_input_filter #(
      .FILT_CYCLES(FILT_CYCLES),
      .IDLE_LVL   (SENSE_IDLE[g])
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (tp_in[g]),
      .hit  (sense_hit[g])
    );
  end

  tamper_arm_gate #(
    .RECOV_CYCLES(RECOV_CYCLES)
  ) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .main_ok(main_ok),
    .armed  (armed)
  );

  assign phys_hit = |sense_hit;
  assign volt_hit = ovr_volt | und_volt;
  assign temp_hit = ovr_temp | und_temp;
  assign any_cond = phys_hit | volt_hit | temp_hit;
  assign raise    = armed & any_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_n <= 1'b1;
      aux_en  <= 1'b1;
      aux_gnd <= 1'b0;
    end else begin
      alarm_n           <= ~raise;
      {aux_en, aux_gnd} <= aux_drive(MODE, raise);
    end
  end

endmodule

// File: rtl/tamper_alarm_chk.sv
module tamper_alarm_chk #(
  parameter int unsigned AUX_MODE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic armed,
  input logic phys_hit,
  input logic volt_hit,
  input logic temp_hit,
  input logic any_cond,
  input logic alarm_n,
  input logic aux_en,
  input logic aux_gnd
);

  assert_quiet_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> alarm_n);

  assert_arm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  assert_phys_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && phys_hit |=> !alarm_n);

  assert_volt_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && volt_hit |=> !alarm_n);

  assert_temp_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && temp_hit |=> !alarm_n);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cond |=> alarm_n);

  assert_aux_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_n |-> aux_en && !aux_gnd);

  if (AUX_MODE == 0) begin : g_on
    assert_aux_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_n |-> aux_en && !aux_gnd);
  end else if (AUX_MODE == 1) begin : g_float
    assert_aux_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_n |-> !aux_en && !aux_gnd);
  end else begin : g_gnd
    assert_aux_gnd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_n |-> !aux_en && aux_gnd);
  end

endmodule

bind tamper_alarm_top tamper_alarm_chk #(.AUX_MODE(AUX_MODE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .armed   (armed),
  .phys_hit(phys_hit),
  .volt_hit(volt_hit),
  .temp_hit(temp_hit),
  .any_cond(any_cond),
  .alarm_n (alarm_n),
  .aux_en  (aux_en),
  .aux_gnd (aux_gnd)
);

// File: tb/tamper_alarm_top_tb.sv
module tamper_alarm_top_tb;
  localparam int unsigned F = 8;
  localparam int unsigned RC = 40;
  localparam logic [3:0] IDLE = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_ok = 1'b0;
  logic [3:0] tp_in = IDLE;
  logic       ovr_volt = 1'b0, und_volt = 1'b0, ovr_temp = 1'b0, und_temp = 1'b0;
  logic       alarm_n, aux_en, aux_gnd;
  logic       al_f, en_f, gnd_f, al_o, en_o, gnd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tamper_alarm_top #(.FILT_CYCLES(F), .RECOV_CYCLES(RC), .AUX_MODE(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .tp_in(tp_in),
    .ovr_volt(ovr_volt), .und_volt(und_volt), .ovr_temp(ovr_temp), .und_temp(und_temp),
    .alarm_n(alarm_n), .aux_en(aux_en), .aux_gnd(aux_gnd));

  tamper_alarm_top #(.FILT_CYCLES(F), .RECOV_CYCLES(RC), .AUX_MODE(1)) u_dut_float (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .tp_in(tp_in),
    .ovr_volt(ovr_volt), .und_volt(und_volt), .ovr_temp(ovr_temp), .und_temp(und_temp),
    .alarm_n(al_f), .aux_en(en_f), .aux_gnd(gnd_f));

  tamper_alarm_top #(.FILT_CYCLES(F), .RECOV_CYCLES(RC), .AUX_MODE(0)) u_dut_on (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .tp_in(tp_in),
    .ovr_volt(ovr_volt), .und_volt(und_volt), .ovr_temp(ovr_temp), .und_temp(und_temp),
    .alarm_n(al_o), .aux_en(en_o), .aux_gnd(gnd_o));

  task automatic chk(string req, string what, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected {alarm_n, aux_en, aux_gnd} of the three variants.
  function automatic logic [8:0] expect_all(logic active);
    return active ? {3'b001, 3'b000, 3'b010} : {3'b110, 3'b110, 3'b110};
  endfunction

  task automatic chk_all(string req, string what, logic active);
    logic [8:0] e;
    e = expect_all(active);
    chk(req, {what, " mode2"}, {3'b000, alarm_n, aux_en, aux_gnd}, {3'b000, e[8:6]});
    chk("R10", {what, " mode1"}, {3'b000, al_f, en_f, gnd_f}, {3'b000, e[5:3]});
    chk("R10", {what, " mode0"}, {3'b000, al_o, en_o, gnd_o}, {3'b000, e[2:0]});
  endtask

  task automatic t_reset;
    chk_all("R3", "reset idle", 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk_all("R3", "after reset", 1'b0);
  endtask

  task automatic t_cold_battery;
    ovr_volt = 1'b1;
    tp_in = IDLE ^ 4'b0001;
    cyc(100);
    chk("R8", "no arm on battery", {5'b0, alarm_n}, 6'd1);
    ovr_volt = 1'b0;
    tp_in = IDLE;
    cyc(F + 4);
  endtask

  task automatic t_arming;
    ovr_volt = 1'b1;
    main_ok = 1'b1;
    cyc(20);
    main_ok = 1'b0;
    cyc(1);
    main_ok = 1'b1;
    cyc(RC - 5);
    chk("R8", "count restarted, still quiet", {5'b0, alarm_n}, 6'd1);
    cyc(7);
    chk_all("R8", "armed after recovery", 1'b1);
    ovr_volt = 1'b0;
    cyc(2);
    chk_all("R4", "release after flag clear", 1'b0);
  endtask

  task automatic t_battery_armed;
    main_ok = 1'b0;
    und_volt = 1'b1;
    cyc(2);
    chk("R9", "armed on battery, und_volt R5", {5'b0, alarm_n}, 6'd0);
    und_volt = 1'b0;
    cyc(2);
    chk("R4", "und_volt cleared", {5'b0, alarm_n}, 6'd1);
  endtask

  task automatic t_temperature;
    ovr_temp = 1'b1;
    cyc(2);
    chk("R6", "ovr_temp", {5'b0, alarm_n}, 6'd0);
    ovr_temp = 1'b0;
    cyc(2);
    chk("R6", "ovr_temp clear", {5'b0, alarm_n}, 6'd1);
    und_temp = 1'b1;
    cyc(2);
    chk("R6", "und_temp", {5'b0, alarm_n}, 6'd0);
    und_temp = 1'b0;
    cyc(2);
    chk("R6", "und_temp clear", {5'b0, alarm_n}, 6'd1);
  endtask

  task automatic t_each_input;
    for (int i = 0; i < 4; i++) begin
      tp_in = IDLE ^ (4'b0001 << i);
      cyc(F - 1);
      chk("R7", $sformatf("input %0d not yet accepted", i), {5'b0, alarm_n}, 6'd1);
      cyc(5);
      chk_all("R1", $sformatf("input %0d tamper level R2", i), 1'b1);
      tp_in = IDLE;
      cyc(F + 4);
      chk_all("R4", $sformatf("input %0d back idle", i), 1'b0);
    end
  endtask

  task automatic t_glitch;
    logic seen_low;
    seen_low = 1'b0;
    tp_in = IDLE ^ 4'b0010;
    for (int k = 0; k < F - 1; k++) begin
      @(negedge clk);
      if (!alarm_n) seen_low = 1'b1;
    end
    tp_in = IDLE;
    for (int k = 0; k < 2 * F; k++) begin
      @(negedge clk);
      if (!alarm_n) seen_low = 1'b1;
    end
    chk("R7", "short pulse ignored", {5'b0, seen_low}, 6'd0);
    tp_in = 4'b1111;
    cyc(F + 4);
    chk("R1", "input 0 at high level is idle, input 3 high is tamper", {5'b0, alarm_n}, 6'd0);
    tp_in = IDLE;
    cyc(F + 4);
  endtask

  task automatic t_overlap;
    ovr_temp = 1'b1;
    tp_in = IDLE ^ 4'b0100;
    cyc(F + 4);
    chk("R4", "two conditions", {5'b0, alarm_n}, 6'd0);
    ovr_temp = 1'b0;
    cyc(3);
    chk("R4", "one condition left", {5'b0, alarm_n}, 6'd0);
    tp_in = IDLE;
    cyc(F + 4);
    chk("R4", "all cleared", {5'b0, alarm_n}, 6'd1);
  endtask

  task automatic t_rearm;
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    chk_all("R3", "reset mid-run", 1'b0);
    rst_n = 1'b1;
    main_ok = 1'b0;
    ovr_temp = 1'b1;
    cyc(50);
    chk("R9", "disarmed by reset", {5'b0, alarm_n}, 6'd1);
    main_ok = 1'b1;
    cyc(RC + 3);
    chk("R8", "rearmed", {5'b0, alarm_n}, 6'd0);
    ovr_temp = 1'b0;
    cyc(2);
    chk("R4", "rearmed clear", {5'b0, alarm_n}, 6'd1);
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_cold_battery();
    t_arming();
    t_battery_armed();
    t_temperature();
    t_each_input();
    t_glitch();
    t_overlap();
    t_rearm();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule